// File: doc/BRIEF.md
# Dual-Polynomial CRC32 Execution Unit

This unit executes the CRC accumulate operations of a processor pipeline. Each operation takes a running 32-bit CRC and a data operand of up to 64 bits. It folds 1, 2, 4 or 8 data bytes into the CRC and returns a new 32-bit value. A select bit picks one of two generator polynomials: the common CRC-32 polynomial or the Castagnoli polynomial. The unit works on reflected bits and applies no pre- or post-inversion. Software that wants a standard checksum inverts the value before the first operation and after the last one.

The unit also applies the rules of the execution state. In 32-bit state, the 8-byte form is illegal and raises an undefined-instruction flag. In the same state the operation is conditional, so a failed condition suppresses the write. A destination index travels with the operation and is returned alongside the write-enable, and index 15 gets no special treatment. Every accepted operation produces exactly one output pulse, one cycle later.

Top module: `crc32_exec_unit`

## Requirements
- R1: With `poly_sel` = 0 the fold uses the reflected CRC-32 polynomial 0xEDB88320. With `poly_sel` = 1 it uses the reflected Castagnoli polynomial 0x82F63B78.
- R2: `size_code` picks the byte count: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes, 3 gives 8 bytes.
- R3: The starting CRC is `acc_in[31:0]`. Bits `acc_in[63:32]` have no effect on the result in either state.
- R4: Bytes are folded least-significant first (`data_in[7:0]` first). Data bytes above the selected count have no effect.
- R5: With `mode32` = 1 and `size_code` = 3, `undef_flag` pulses with `out_valid`, `wr_en` stays low and `result` keeps its previous value.
- R6: With `mode32` = 1 and `cond_pass` = 0, `wr_en` stays low and `result` keeps its previous value. With `mode32` = 0, `cond_pass` is ignored.
- R7: `dst_idx` is returned on `wr_idx` with the output pulse. Index 15 writes normally and raises no flag.
- R8: `out_valid` is high exactly in the cycle after each cycle where `in_valid` is high. `result`, `wr_en`, `undef_flag` and `wr_idx` are registered and belong to that pulse. `wr_en` and `undef_flag` are never high without `out_valid`.
- R9: The unit applies no internal inversion. When "123456789" is chained through 1-byte operations, with the start and the end inverted outside the unit, the result is 0xCBF43926 (`poly_sel` = 0) and 0xE3069283 (`poly_sel` = 1).
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle pulse that presents an operation |
| acc_in | input | 64 | Running CRC operand; only the low 32 bits are used |
| data_in | input | 64 | Message operand, little-endian bytes |
| size_code | input | 2 | Byte count code (0:1, 1:2, 2:4, 3:8) |
| poly_sel | input | 1 | 0 selects CRC-32, 1 selects Castagnoli |
| mode32 | input | 1 | 1 means 32-bit execution state |
| cond_pass | input | 1 | Condition result, used in 32-bit state |
| dst_idx | input | 4 | Destination register index |
| out_valid | output | 1 | One-cycle completion pulse |
| result | output | 32 | Registered CRC result |
| wr_en | output | 1 | Write the result to `wr_idx` |
| wr_idx | output | 4 | Destination index of the completed operation |
| undef_flag | output | 1 | Illegal size for the execution state |

## Verification
Two conditions are hard to observe from the ports: a suppressed write, and data bytes that must play no part. A suppressed write only shows when a known value is already in the result register. The stimulus therefore always precedes an undefined or failed-condition operation with a write of a distinct value, then checks that the value survives. Ignored bytes and ignored upper CRC bits are covered by vectors that fill those bits with nonzero patterns. Each result is compared with a bitwise reference model and with the two published check values.

// File: rtl/crc32u_pkg.sv
package crc32u_pkg;

    localparam int CRC_W = 32;

    localparam logic [CRC_W-1:0] POLY_STD_REFL  = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] POLY_CAST_REFL = 32'h82F6_3B78;

    typedef struct packed {
        logic             valid;
        logic             wr;
        logic             undef;
        logic [3:0]       idx;
        logic [CRC_W-1:0] crc;
    } crc_out_st_t;

endpackage

// File: rtl/crc32u_byte_step.sv
module crc32u_byte_step #(
    parameter int CRC_W = 32
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       byte_in,
    input  logic [CRC_W-1:0] poly,
    output logic [CRC_W-1:0] crc_out
);
    always_comb begin
        logic [CRC_W-1:0] c;
        c = crc_in ^ {{(CRC_W-8){1'b0}}, byte_in};
        for (int b = 0; b < 8; b++) begin
            if (c[0]) c = (c >> 1) ^ poly;
            else      c = c >> 1;
        end
        crc_out = c;
    end
endmodule

// File: rtl/crc32u_legality.sv
module crc32u_legality #(
    parameter int SZ_W = 2
) (
    input  logic            valid,
    input  logic            mode32,
    input  logic            cond_pass,
    input  logic [SZ_W-1:0] size_code,
    output logic            undef,
    output logic            wr
);
    localparam logic [SZ_W-1:0] SZ_MAX = '1;

    always_comb begin
        undef = valid && mode32 && (size_code == SZ_MAX);
        wr    = valid && !undef && (!mode32 || cond_pass);
    end
endmodule

// File: rtl/crc32_exec_unit.sv
module crc32_exec_unit
    import crc32u_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [1:0]        size_code,
    input  logic              poly_sel,
    input  logic              mode32,
    input  logic              cond_pass,
    input  logic [IDX_W-1:0]  dst_idx,
    output logic              out_valid,
    output logic [31:0]       result,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              undef_flag
);
    localparam int NBYTES = DATA_W / 8;
    localparam int LOG_N  = $clog2(NBYTES);

    logic [CRC_W-1:0] chain [0:NBYTES];
    logic [CRC_W-1:0] poly;
    logic [CRC_W-1:0] folded;
    logic             undef_c;
    logic             wr_c;

    crc_out_st_t st_d, st_q;

    assign poly     = poly_sel ? POLY_CAST_REFL : POLY_STD_REFL;
    assign chain[0] = acc_in[CRC_W-1:0];

    genvar g;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_fold
            crc32u_byte_step #(.CRC_W(CRC_W)) u_step (
                .crc_in (chain[g]),
                .byte_in(data_in[8*g +: 8]),
                .poly   (poly),
                .crc_out(chain[g+1])
            );
        end
    endgenerate

    crc32u_legality #(.SZ_W(2)) u_legal (
        .valid    (in_valid),
        .mode32   (mode32),
        .cond_pass(cond_pass),
        .size_code(size_code),
        .undef    (undef_c),
        .wr       (wr_c)
    );

    always_comb begin
        folded = chain[1];
        for (int k = 0; k <= LOG_N; k++) begin
            if (int'(size_code) == k) folded = chain[1 << k];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.wr    = wr_c;
        st_d.undef = undef_c;
        if (in_valid) st_d.idx = dst_idx;
        if (wr_c)     st_d.crc = folded;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign wr_en      = st_q.wr;
    assign undef_flag = st_q.undef;
    assign wr_idx     = st_q.idx;
    assign result     = st_q.crc;

    AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || undef_flag) |-> out_valid); // R8
    AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> !wr_en); // R5
    AST_PRED_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode32 && !cond_pass) |=> !wr_en); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wr_en) |-> $stable(result)); // R5
    AST_WIDE_LEGAL_64: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode32) |=> (wr_en && !undef_flag)); // R6
endmodule

// File: tb/tb_crc32_exec_unit.sv
module tb_crc32_exec_unit;

    typedef struct packed {
        logic [63:0] acc;
        logic [63:0] data;
        logic [1:0]  sz;
        logic        psel;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0031, 2'd0, 1'b0}, // R1 R2
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0031, 2'd0, 1'b1}, // R1
        '{64'hDEAD_BEEF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_3412, 2'd1, 1'b0}, // R3 R4
        '{64'h1234_5678_0BAD_F00D, 64'hAAAA_5555_8765_4321, 2'd2, 1'b1}, // R3 R4
        '{64'h0000_0000_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 2'd3, 1'b0}, // R2
        '{64'hFFFF_FFFF_0000_0001, 64'h0123_4567_89AB_CDEF, 2'd3, 1'b1}, // R2 R3
        '{64'h0000_0000_A5A5_A5A5, 64'hFF00_FF00_FF00_FF80, 2'd0, 1'b1}, // R4
        '{64'h0000_0000_5A5A_5A5A, 64'h0000_0000_0000_0001, 2'd2, 1'b0}, // R4
        '{64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'd3, 1'b0}, // R4
        '{64'h7777_0000_C0FF_EE00, 64'h1111_2222_3333_4444, 2'd1, 1'b1}  // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] acc_in = '0;
    logic [63:0] data_in = '0;
    logic [1:0]  size_code = '0;
    logic        poly_sel = 1'b0;
    logic        mode32 = 1'b0;
    logic        cond_pass = 1'b1;
    logic [3:0]  dst_idx = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic        undef_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    crc32_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in),
        .data_in(data_in), .size_code(size_code), .poly_sel(poly_sel),
        .mode32(mode32), .cond_pass(cond_pass), .dst_idx(dst_idx),
        .out_valid(out_valid), .result(result), .wr_en(wr_en),
        .wr_idx(wr_idx), .undef_flag(undef_flag)
    );

    function automatic logic [31:0] ref_crc(input logic [31:0] init,
                                            input logic [63:0] data,
                                            input int nbytes,
                                            input logic psel);
        logic [31:0] c;
        logic [31:0] p;
        p = psel ? 32'h82F63B78 : 32'hEDB88320;
        c = init;
        for (int i = 0; i < nbytes * 8; i++) begin
            if (c[0] ^ data[i]) c = (c >> 1) ^ p;
            else                c = c >> 1;
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] a, input logic [63:0] d,
                          input logic [1:0] sz, input logic ps,
                          input logic m32, input logic cp, input logic [3:0] ix);
        @(negedge clk);
        acc_in = a; data_in = d; size_code = sz; poly_sel = ps;
        mode32 = m32; cond_pass = cp; dst_idx = ix; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] crc;
        logic [31:0] prev;
        string msg;
        msg = "123456789";

        repeat (3) @(negedge clk);
        check("R10 out_valid reset", {63'd0, out_valid}, 64'd0);
        check("R10 result reset", {32'd0, result}, 64'd0);
        check("R10 flags reset", {62'd0, wr_en, undef_flag}, 64'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_op(VECS[v].acc, VECS[v].data, VECS[v].sz, VECS[v].psel, 1'b0, 1'b1, 4'(v));
            check("R8 out_valid pulse", {63'd0, out_valid}, 64'd1);
            check("R1 R2 R3 R4 vector result", {32'd0, result},
                  {32'd0, ref_crc(VECS[v].acc[31:0], VECS[v].data, 1 << VECS[v].sz, VECS[v].psel)});
            check("R7 wr_idx", {60'd0, wr_idx}, 64'(v));
            @(negedge clk);
            check("R8 single pulse", {63'd0, out_valid}, 64'd0);
        end

        // R9: check values through chained byte operations
        for (int ps = 0; ps < 2; ps++) begin
            crc = 32'hFFFF_FFFF;
            for (int i = 0; i < 9; i++) begin
                run_op({32'hFFFF_0000, crc}, {56'd0, msg[i]}, 2'd0, ps[0], 1'b0, 1'b1, 4'd1);
                crc = result;
            end
            check("R9 check value", {32'd0, crc ^ 32'hFFFF_FFFF},
                  ps == 0 ? 64'hCBF43926 : 64'hE3069283);
        end

        // R5: 8-byte size in 32-bit state
        run_op(64'd0, 64'h55, 2'd0, 1'b0, 1'b1, 1'b1, 4'd3);
        prev = result;
        check("R6 mode32 write", {63'd0, wr_en}, 64'd1);
        run_op(64'h1234, 64'h0123_4567_89AB_CDEF, 2'd3, 1'b0, 1'b1, 1'b1, 4'd4);
        check("R5 undef_flag", {63'd0, undef_flag}, 64'd1);
        check("R5 no write", {63'd0, wr_en}, 64'd0);
        check("R5 result held", {32'd0, result}, {32'd0, prev});
        check("R8 out_valid with undef", {63'd0, out_valid}, 64'd1);

        // R6: failed condition in 32-bit state
        run_op(64'h9999, 64'hABCD, 2'd1, 1'b1, 1'b1, 1'b0, 4'd5);
        check("R6 predicated wr_en", {63'd0, wr_en}, 64'd0);
        check("R6 predicated no undef", {63'd0, undef_flag}, 64'd0);
        check("R6 predicated result held", {32'd0, result}, {32'd0, prev});

        // R6: condition ignored in 64-bit state
        run_op(64'h9999, 64'hABCD, 2'd1, 1'b1, 1'b0, 1'b0, 4'd6);
        check("R6 64-bit ignores cond", {63'd0, wr_en}, 64'd1);
        check("R6 64-bit result", {32'd0, result}, {32'd0, ref_crc(32'h9999, 64'hABCD, 2, 1'b1)});

        // R5 contrast: 8 bytes legal in 64-bit state
        run_op(64'd7, 64'h0123_4567_89AB_CDEF, 2'd3, 1'b1, 1'b0, 1'b1, 4'd2);
        check("R5 64-bit size 3 legal", {62'd0, wr_en, undef_flag}, 64'd2);

        // R7: index 15 in 32-bit state
        run_op(64'hFFFF_FFFF_1111_2222, 64'hFFFF_FFFF_DEAD_BEEF, 2'd2, 1'b0, 1'b1, 1'b1, 4'd15);
        check("R7 idx15 write", {62'd0, wr_en, undef_flag}, 64'd2);
        check("R7 idx15 wr_idx", {60'd0, wr_idx}, 64'd15);
        check("R7 R3 idx15 result", {32'd0, result},
              {32'd0, ref_crc(32'h1111_2222, 64'hDEAD_BEEF, 4, 1'b0)});

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule